// File: doc/BRIEF.md
# Multi-word bit-field left shifter

This block moves a contiguous run of bits one position toward the more significant end. The bits live in consecutive 16-bit words of a word-addressed memory. A start command supplies three values: the address of the lowest word, the bit offset where the run begins inside that word, and the run length in bits. A sequential engine then visits each word that the run covers. It reads the word, merges in the shifted bits and writes the word back. It works from the base address upward, so the bit that leaves the top of one word enters the bottom of the next.

The engine writes a zero into the lowest bit of the run. The bit that held the highest position of the run before the shift ends up in a carry flag. Bits that lie below the run in its first word, or above the run in its last word, are written back unchanged. A run of zero length is a legal command: the engine touches no memory word, keeps the carry as it was and signals completion at once. The caller must place all words of the run in one contiguous address region, because the engine only ever increments the address.

Top module: `bitfield_lshift_engine`

## Requirements
- R1: After a command, every bit at run position p (1 <= p < length) holds the value that run position p-1 held before. Run position 0 is bit `field_ofs` of word `base_addr`, and positions count upward through the bits of a word and then into the next higher address.
- R2: After a command with a nonzero length, run position 0 holds 0.
- R3: When `done` pulses after a command with a nonzero length, `carry` equals the value that run position length-1 held before the command.
- R4: Memory bits outside the run keep their values. This covers the bits below the offset in the first word, the bits above the run end in the last word, and every word outside the run.
- R5: Each word of the run is read, on a cycle with `mem_rd_en` high, and then written on the very next cycle with `mem_wr_en` high at the same address. Read and write never fall on the same cycle. Word addresses start at `base_addr` and rise by one per word.
- R6: A command covering N words raises `done` for exactly one cycle, 2N+1 rising edges after the edge that accepted `start`. `busy` is high from that accepting edge until `done` falls.
- R7: A `start` that arrives while `busy` is high is ignored. The running command completes exactly as if that `start` had never been given.
- R8: A command with length 0 makes no memory access and leaves `carry` unchanged. It raises `done` on the edge after the accepting edge.
- R9: While `rst_n` is low on a rising edge, the block enters an idle state: `busy`, `done`, `carry`, `mem_rd_en` and `mem_wr_en` are all 0.
- R10: Any offset from 0 to 15 is accepted together with any length up to 65535. This includes a run that ends exactly on a word boundary and a run that spans many words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Command strobe, accepted only while idle |
| base_addr | input | ADDR_W (16) | Address of the lowest word of the run |
| field_ofs | input | 4 | Bit offset of run position 0 in the lowest word |
| field_len | input | LEN_W (16) | Run length in bits, 0 to 65535 |
| busy | output | 1 | High while a command is in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Bit that was shifted out of the top of the run |
| mem_rd_en | output | 1 | Memory read request; data is returned one cycle later |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W (16) | Word address for the read or the write |
| mem_wdata | output | 16 | Data to write |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd_en` |

## Verification
A wrong internal state in this block shows up in memory contents within one write cycle. A bad word index or end bit produces a wrong mask. A wrong mask either corrupts a neighbouring bit outside the run, or it leaves a run bit unshifted in the word being written. A stale inter-word link bit shows up as a wrong bit 0 or a wrong offset bit in the next word. A wrong word counter shows up at the ports in two ways: `done` arrives at a cycle other than 2N+1, and the memory sees an access count other than 2N. A carry captured from the wrong word differs from the top run bit at the `done` pulse.

// File: rtl/bfs_pkg.sv
// Package: shared state type for the bit-field shifter.
// Assumes: word width is a power of two; the engine uses four states.
package bfs_pkg;

    // Engine phases: idle, read request, write back, completion pulse
    typedef enum logic [1:0] {
        BFS_IDLE  = 2'd0,
        BFS_READ  = 2'd1,
        BFS_WRITE = 2'd2,
        BFS_FIN   = 2'd3
    } bfs_state_e;

endpackage

// File: rtl/bfs_span_calc.sv
// Module: bfs_span_calc
// Finds, from the offset and the length, the index of the last word and
// the bit position of the run end inside that word.
// Assumes: DATA_W is a power of two; the result is only used when the
// length is nonzero.
module bfs_span_calc #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    parameter int OFS_W  = $clog2(DATA_W),
    parameter int CNT_W  = LEN_W + 1 - OFS_W
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] last_idx,
    output logic [OFS_W-1:0] end_bit,
    output logic             empty
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] top_pos;

    // Global position of the highest run bit, counted from bit 0 of the base word
    always_comb begin
        top_pos  = SUM_W'(ofs) + SUM_W'(len) - SUM_W'(1);
        empty    = (len == '0);
        last_idx = top_pos[SUM_W-1:OFS_W];
        end_bit  = top_pos[OFS_W-1:0];
    end

endmodule

// File: rtl/bfs_mask_gen.sv
// Module: bfs_mask_gen
// Builds the per-word mask of run bits, the one-hot mark of the lowest run
// bit and the index of the highest run bit for the current word.
// Assumes: lo <= hi whenever the word belongs to a nonempty run.
module bfs_mask_gen #(
    parameter int DATA_W = 16,
    parameter int OFS_W  = $clog2(DATA_W)
) (
    input  logic              is_first,
    input  logic              is_last,
    input  logic [OFS_W-1:0]  start_bit,
    input  logic [OFS_W-1:0]  stop_bit,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] low_hot,
    output logic [OFS_W-1:0]  hi_bit
);
    logic [OFS_W-1:0] lo_bit;

    // Lower bound only in the first word, upper bound only in the last
    always_comb begin
        lo_bit = is_first ? start_bit : '0;
        hi_bit = is_last  ? stop_bit  : OFS_W'(DATA_W - 1);
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // Bit i is in the run when it lies between the two bounds
        always_comb begin
            mask[i]    = (OFS_W'(i) >= lo_bit) && (OFS_W'(i) <= hi_bit);
            low_hot[i] = (OFS_W'(i) == lo_bit);
        end
    end

endmodule

// File: rtl/bfs_word_shift.sv
// Module: bfs_word_shift
// Shifts the masked bits of one word up by one position. The incoming link
// bit fills the lowest masked bit and the highest masked bit leaves as
// link_out. Unmasked bits pass through.
// Assumes: low_hot marks a bit that is inside mask.
module bfs_word_shift #(
    parameter int DATA_W = 16,
    parameter int OFS_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] low_hot,
    input  logic [OFS_W-1:0]  hi_bit,
    input  logic              link_in,
    output logic [DATA_W-1:0] word_out,
    output logic              link_out
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            // Bit 0 can only be the lowest run bit, never a shifted one
            always_comb word_out[i] = mask[i] ? link_in : word_in[i];
        end else begin : g_upper
            // Lowest run bit takes the link; other run bits take their neighbour
            always_comb begin
                if (!mask[i])
                    word_out[i] = word_in[i];
                else if (low_hot[i])
                    word_out[i] = link_in;
                else
                    word_out[i] = word_in[i-1];
            end
        end
    end

    // The bit leaving the top of the run in this word
    always_comb link_out = word_in[hi_bit];

endmodule

// File: rtl/bitfield_lshift_engine.sv
// Module: bitfield_lshift_engine
// Read-modify-write engine that shifts a bit run spread over consecutive
// memory words up by one bit. It inserts a zero at the bottom of the run and
// reports the bit shifted out of the top in carry.
// Assumes: the memory returns read data one cycle after mem_rd_en; the run
// lies in one contiguous address region; DATA_W is a power of two.
module bitfield_lshift_engine #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    localparam int OFS_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFS_W-1:0]  field_ofs,
    input  logic [LEN_W-1:0]  field_len,
    output logic              busy,
    output logic              done,
    output logic              carry,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import bfs_pkg::*;

    localparam int CNT_W = LEN_W + 1 - OFS_W;

    bfs_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  last_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [OFS_W-1:0]  end_q;
    logic              link_q;
    logic              carry_q;

    logic [CNT_W-1:0]  span_last;
    logic [OFS_W-1:0]  span_end;
    logic              span_empty;
    logic [DATA_W-1:0] word_mask;
    logic [DATA_W-1:0] word_low;
    logic [OFS_W-1:0]  word_hi;
    logic              word_link;
    logic              at_last;

    // Run geometry from the command inputs
    bfs_span_calc #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .OFS_W  (OFS_W),
        .CNT_W  (CNT_W)
    ) u_span (
        .ofs      (field_ofs),
        .len      (field_len),
        .last_idx (span_last),
        .end_bit  (span_end),
        .empty    (span_empty)
    );

    // Word position relative to the run
    always_comb at_last = (idx_q == last_q);

    bfs_mask_gen #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_mask (
        .is_first  (idx_q == '0),
        .is_last   (at_last),
        .start_bit (ofs_q),
        .stop_bit  (end_q),
        .mask      (word_mask),
        .low_hot   (word_low),
        .hi_bit    (word_hi)
    );

    bfs_word_shift #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_shift (
        .word_in  (mem_rdata),
        .mask     (word_mask),
        .low_hot  (word_low),
        .hi_bit   (word_hi),
        .link_in  (link_q),
        .word_out (mem_wdata),
        .link_out (word_link)
    );

    // Sequencer: accept a command, then read and write each word in turn
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BFS_IDLE;
            addr_q  <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            ofs_q   <= '0;
            end_q   <= '0;
            link_q  <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            case (state_q)
                BFS_IDLE: begin
                    if (start) begin
                        addr_q  <= base_addr;
                        idx_q   <= '0;
                        last_q  <= span_last;
                        ofs_q   <= field_ofs;
                        end_q   <= span_end;
                        link_q  <= 1'b0;
                        state_q <= span_empty ? BFS_FIN : BFS_READ;
                    end
                end
                BFS_READ: begin
                    state_q <= BFS_WRITE;
                end
                BFS_WRITE: begin
                    link_q <= word_link;
                    if (at_last) begin
                        carry_q <= word_link;
                        state_q <= BFS_FIN;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        addr_q  <= addr_q + 1'b1;
                        state_q <= BFS_READ;
                    end
                end
                default: begin
                    state_q <= BFS_IDLE;
                end
            endcase
        end
    end

    // Port decode from the current phase
    always_comb begin
        busy      = (state_q != BFS_IDLE);
        done      = (state_q == BFS_FIN);
        mem_rd_en = (state_q == BFS_READ);
        mem_wr_en = (state_q == BFS_WRITE);
        mem_addr  = addr_q;
        carry     = carry_q;
    end

endmodule

// File: rtl/bfs_lshift_checker.sv
// Module: bfs_lshift_checker
// Protocol and timing properties of the shifter, observed at its ports.
// Assumes: it is bound to bitfield_lshift_engine with matching widths.
module bfs_lshift_checker #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  field_len,
    input logic              busy,
    input logic              done,
    input logic              carry,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (mem_wr_en && $stable(mem_addr)));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (!mem_rd_en || (mem_addr == $past(mem_addr) + 1'b1)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_access_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en || done) |-> busy);

    assert_empty_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && field_len == '0) |=> (done && !mem_rd_en && !mem_wr_en));

    assert_carry_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_en |=> $stable(carry));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind bitfield_lshift_engine bfs_lshift_checker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .field_len (field_len),
    .busy      (busy),
    .done      (done),
    .carry     (carry),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr)
);

// File: tb/sim_bitfield_lshift_engine.sv
module sim_bitfield_lshift_engine;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [3:0]  field_ofs = '0;
    logic [15:0] field_len = '0;
    logic        busy, done, carry;
    logic        mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem   [DEPTH];
    logic [15:0] model [DEPTH];

    int checks = 0;
    int errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    bit exp_carry = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bitfield_lshift_engine #(.DATA_W(16), .ADDR_W(AW), .LEN_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .field_ofs(field_ofs), .field_len(field_len), .busy(busy), .done(done),
        .carry(carry), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory with one-cycle read latency, plus access counters
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            n_rd = n_rd + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            n_wr = n_wr + 1;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit mbit(input int b, input int g);
        return model[(b + g / 16) % DEPTH][g % 16];
    endfunction

    task automatic set_mbit(input int b, input int g, input bit v);
        model[(b + g / 16) % DEPTH][g % 16] = v;
    endtask

    task automatic run_op(input int b, input int o, input int l, input bit poke);
        int words;
        int n;
        int bad_r1, bad_r2, bad_r4;
        for (int a = 0; a < DEPTH; a++) model[a] = mem[a];
        if (l > 0) begin
            exp_carry = mbit(b, o + l - 1);
            for (int g = o + l - 1; g > o; g--) set_mbit(b, g, mbit(b, g - 1));
            set_mbit(b, o, 1'b0);
        end
        words = (l == 0) ? 0 : ((o + l - 1) / 16 + 1);
        n_rd = 0;
        n_wr = 0;
        @(negedge clk);
        base_addr = AW'(b);
        field_ofs = 4'(o);
        field_len = 16'(l);
        start = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            start = 1'b0;
            if (poke && n == 3) begin
                base_addr = AW'(b + 1);
                field_ofs = 4'(o + 5);
                field_len = 16'd0;
                start = 1'b1;
            end
            if (done || n > 20000) break;
        end
        start = 1'b0;
        check(poke ? "R7 done timing with start while busy" : "R6 done timing",
              n, (l == 0) ? 1 : 2 * words + 1);
        check("R6 busy during done", busy, 1);
        if (l > 0) check("R3 carry", carry, exp_carry);
        else       check("R8 carry unchanged", carry, exp_carry);
        check("R8/R5 reads", n_rd, words);
        check("R5 writes", n_wr, words);
        @(negedge clk);
        check("R6 done single pulse", done, 0);
        check("R6 busy released", busy, 0);
        bad_r1 = 0; bad_r2 = 0; bad_r4 = 0;
        for (int a = 0; a < DEPTH; a++) begin
            for (int k = 0; k < 16; k++) begin
                int g;
                g = ((a - b + DEPTH) % DEPTH) * 16 + k;
                if (mem[a][k] !== model[a][k]) begin
                    if (l > 0 && g == o) bad_r2++;
                    else if (l > 0 && g > o && g < o + l) bad_r1++;
                    else bad_r4++;
                end
            end
        end
        check(poke ? "R7 run bits after ignored start" : "R1/R10 run bits moved", bad_r1, 0);
        check("R2 zero inserted", bad_r2, 0);
        check("R4 outside bits kept", bad_r4, 0);
    endtask

    task automatic rand_op(input bit poke);
        int b, o, l, maxl;
        b = $urandom_range(0, DEPTH - 8);
        o = $urandom_range(0, 15);
        maxl = (DEPTH - b) * 16 - o;
        if (maxl > 300) maxl = 300;
        l = $urandom_range(poke ? 20 : 1, maxl);
        run_op(b, o, l, poke);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < DEPTH; a++) mem[a] = 16'($urandom);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset busy", busy, 0);
        check("R9 reset done", done, 0);
        check("R9 reset carry", carry, 0);
        check("R9 reset rd", mem_rd_en, 0);
        check("R9 reset wr", mem_wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners
        run_op(10, 0, 16, 0);     // R10 exactly one whole word
        run_op(20, 15, 1, 0);     // R10 single top bit
        run_op(30, 15, 2, 0);     // R10 crosses a boundary
        run_op(40, 3, 0, 0);      // R8 empty command
        run_op(50, 7, 9, 0);      // R10 ends on a word boundary
        run_op(0, 3, 3000, 0);    // R10 many words
        run_op(60, 4, 40, 1);     // R7 start while busy
        run_op(60, 4, 0, 0);      // R8 carry kept after a real command
        for (int i = 0; i < 40; i++) rand_op(i % 8 == 7);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule